// File: doc/BRIEF.md
# Multi-Switch Converter Gate Pattern Generator

This block drives the four gate lines of a multi-input boost converter from a single system clock. Two of the lines, S1 and S2, are pulse-width modulated and limited to a small share of the switching period. The other two, S3 and S4, form a complementary pair that is never on in the same cycle. An interlock separates them with a programmable dead time.

A source select chooses between two pattern sources. The duty source compares a period position against programmed duty words. The counter source steps a 2-bit phase counter four times per period and decodes it into one-hot phases. S1 is taken from the inverted phase MSB, and S3 is formed by gating the decoded phases with that S1 reference. The duty words and the source select are captured only at period boundaries. This way, software writes that land mid-period cannot produce runt pulses.

Top module: `gate_pattern_gen`

## Requirements
- R1: While rst_ni is low, all four gates are low, asynchronously. A clock edge that samples en_i low drives all gates low and returns the period position, phase counter and interlock to their idle state: position 0, phase 0, side S4, no dead time pending.
- R2: The switching period is PERIOD = 4*STEP_CYC clocks. The position runs 0..PERIOD-1 and wraps, and each counter phase lasts STEP_CYC clocks. A gate reflects the position of the previous cycle, so it has one clock of latency.
- R3: With src_sel_i=0 (duty source), s1_o is high during the first min(duty_s1_i, PERIOD/5) positions of each period, and s2_o likewise uses duty_s2_i. Larger words are clamped to that limit.
- R4: With the duty source, the S3 request is high during the first min(duty_s3_i, 4*PERIOD/5) positions, and the S4 request is its complement.
- R5: The duty words and src_sel_i are captured while disabled and at the last position of each period, and at no other time. A change in mid-period has no effect on the gates before the next period.
- R6: With src_sel_i=1 (counter source), the phase counter steps 0,1,2,3 and wraps. Both s1_o and s2_o equal the inverse of the phase MSB, so they are high in phases 0 and 1 and low in phases 2 and 3.
- R7: With the counter source, the S3 request is (P0 and S1) or (P1 and not S1) or (P2 and not S1) or (P3 and S1). This makes it high in phases 0 and 2. The S4 request is its complement.
- R8: s3_o and s4_o are never high in the same cycle.
- R9: When the requested side differs from the current side, both s3_o and s4_o are held low for dead_i clocks, with dead_i read at that edge, and then the new side turns on. With dead_i=0 the swap happens on a single edge. The idle side is S4, so a first request for S3 after enable also waits out the dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces all gates low |
| src_sel_i | input | 1 | Pattern source: 0 duty, 1 counter |
| duty_s1_i | input | DUTY_W | S1 on-time in clocks |
| duty_s2_i | input | DUTY_W | S2 on-time in clocks |
| duty_s3_i | input | DUTY_W | S3 on-time in clocks |
| dead_i | input | DT_W | Dead time between S3 and S4 in clocks |
| s1_o | output | 1 | Gate S1 |
| s2_o | output | 1 | Gate S2 |
| s3_o | output | 1 | Gate S3 |
| s4_o | output | 1 | Gate S4 |

## Verification
The bench drives duty words far above their limits and checks that S1 and S2 stop at one fifth of the period and S3 at four fifths. A missing clamp would stretch those pulses across the whole period. It rewrites the duty words and the source select in mid-period and expects no change before the wrap; a design that loads them early would produce truncated or runt pulses. It sweeps the dead time from zero up to a value longer than the on-window of S3. A wrong count would either overlap S3 and S4 or shift the edges by a cycle, and a design that fails to restart the gap on a reversed request would let the pair chatter. Enable and reset are dropped in mid-period to confirm that the gates fall at once and that the counter source resumes at phase 0 with S3 first.

// File: rtl/gpg_pkg.sv
package gpg_pkg;
  typedef enum logic {
    SRC_DUTY  = 1'b0,
    SRC_COUNT = 1'b1
  } gate_src_e;

  localparam int unsigned N_PWM = 2;
  localparam int unsigned N_PHASE = 4;
endpackage

// File: rtl/gpg_timebase.sv
module gpg_timebase #(
  parameter int unsigned STEP_CYC = 5,
  localparam int unsigned PERIOD = 4 * STEP_CYC,
  localparam int unsigned POS_W  = $clog2(PERIOD),
  localparam int unsigned STEP_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [POS_W-1:0] pos_o,
  output logic [1:0]       phase_o,
  output logic             last_o
);
  logic [POS_W-1:0]  pos_q;
  logic [STEP_W-1:0] step_q;
  logic [1:0]        phase_q;

  assign last_o  = (pos_q == POS_W'(PERIOD - 1));
  assign pos_o   = pos_q;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      step_q  <= '0;
      phase_q <= '0;
    end else if (!en_i) begin
      pos_q   <= '0;
      step_q  <= '0;
      phase_q <= '0;
    end else begin
      pos_q <= last_o ? '0 : pos_q + POS_W'(1);
      if (step_q == STEP_W'(STEP_CYC - 1)) begin
        step_q  <= '0;
        phase_q <= phase_q + 2'd1;
      end else begin
        step_q <= step_q + STEP_W'(1);
      end
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable(phase_q)) |-> (phase_q == $past(phase_q) + 2'd1)) // R6
    else $error("phase skipped");

  AST_POS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(pos_q) < PERIOD) && ((32'(pos_q) / STEP_CYC) == 32'(phase_q))) // R2
    else $error("position and phase out of step");
endmodule

// File: rtl/gpg_pattern.sv
module gpg_pattern
  import gpg_pkg::*;
#(
  parameter int unsigned STEP_CYC = 5,
  parameter int unsigned DUTY_W   = 8,
  localparam int unsigned PERIOD = 4 * STEP_CYC,
  localparam int unsigned POS_W  = $clog2(PERIOD),
  localparam int unsigned CAP_PWM = PERIOD / 5,
  localparam int unsigned CAP_S3  = (4 * PERIOD) / 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              src_sel_i,
  input  logic [DUTY_W-1:0] duty_s1_i,
  input  logic [DUTY_W-1:0] duty_s2_i,
  input  logic [DUTY_W-1:0] duty_s3_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [1:0]        phase_i,
  output logic              s1_o,
  output logic              s2_o,
  output logic              s3_req_o
);
  localparam logic [DUTY_W-1:0] LIM_PWM = DUTY_W'(CAP_PWM);
  localparam logic [DUTY_W-1:0] LIM_S3  = DUTY_W'(CAP_S3);

  gate_src_e         src_q;
  logic [DUTY_W-1:0] duty_in [N_PWM];
  logic [DUTY_W-1:0] duty_q  [N_PWM];
  logic [N_PWM-1:0]  pwm_q;
  logic [N_PWM-1:0]  pwm_d;
  logic [DUTY_W-1:0] s3_duty_q;
  logic [N_PHASE-1:0] phase_hot;
  logic              s1_ref;
  logic              s3_cnt;
  logic              s3_pwm;

  assign duty_in[0] = duty_s1_i;
  assign duty_in[1] = duty_s2_i;

  // one-hot decode of the counter phase
  for (genvar g = 0; g < N_PHASE; g++) begin : g_dec
    assign phase_hot[g] = (phase_i == 2'(g));
  end

  assign s1_ref = ~phase_i[1];
  assign s3_cnt = (phase_hot[0] &  s1_ref) | (phase_hot[1] & ~s1_ref) |
                  (phase_hot[2] & ~s1_ref) | (phase_hot[3] &  s1_ref);
  assign s3_pwm = (32'(pos_i) < 32'(s3_duty_q));

  assign s3_req_o = (src_q == SRC_COUNT) ? s3_cnt : s3_pwm;

  for (genvar c = 0; c < N_PWM; c++) begin : g_pwm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        duty_q[c] <= '0;
      end else if (load_i) begin
        duty_q[c] <= (duty_in[c] > LIM_PWM) ? LIM_PWM : duty_in[c];
      end
    end
    assign pwm_d[c] = (src_q == SRC_COUNT) ? s1_ref : (32'(pos_i) < 32'(duty_q[c]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q     <= SRC_DUTY;
      s3_duty_q <= '0;
      pwm_q     <= '0;
    end else begin
      if (load_i) begin
        src_q     <= gate_src_e'(src_sel_i);
        s3_duty_q <= (duty_s3_i > LIM_S3) ? LIM_S3 : duty_s3_i;
      end
      pwm_q <= en_i ? pwm_d : '0;
    end
  end

  assign s1_o = pwm_q[0];
  assign s2_o = pwm_q[1];

  AST_S1_DUTY_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && src_q == SRC_DUTY && 32'(pos_i) >= CAP_PWM) |=> !s1_o) // R3
    else $error("S1 beyond duty limit");

  AST_S2_DUTY_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && src_q == SRC_DUTY && 32'(pos_i) >= CAP_PWM) |=> !s2_o) // R3
    else $error("S2 beyond duty limit");

  AST_S3_DUTY_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q == SRC_DUTY && 32'(pos_i) >= CAP_S3) |-> !s3_req_o) // R4
    else $error("S3 request beyond limit");

  AST_CNT_S3_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q == SRC_COUNT) |-> (s3_req_o == ~phase_i[0])) // R7
    else $error("counter S3 pattern wrong");
endmodule

// File: rtl/gpg_interlock.sv
module gpg_interlock #(
  parameter int unsigned DT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            req_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            s3_o,
  output logic            s4_o
);
  logic            side_q;   // 1: S3 side, 0: S4 side
  logic            on_q;
  logic [DT_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      side_q <= 1'b0;
      on_q   <= 1'b0;
      gap_q  <= '0;
    end else if (!en_i) begin
      side_q <= 1'b0;
      on_q   <= 1'b0;
      gap_q  <= '0;
    end else if (req_i != side_q) begin
      side_q <= req_i;
      gap_q  <= dead_i;
      on_q   <= (dead_i == '0);
    end else if (gap_q != '0) begin
      gap_q <= gap_q - DT_W'(1);
      on_q  <= (gap_q == DT_W'(1));
    end else begin
      on_q <= 1'b1;
    end
  end

  assign s3_o = on_q &  side_q;
  assign s4_o = on_q & ~side_q;

  AST_PAIR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s3_o && s4_o)) // R8
    else $error("S3 and S4 both on");

  AST_DEAD_S3_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s3_o && !$past(s3_o) && $past(s4_o)) |-> ($past(dead_i) == '0)) // R9
    else $error("S3 on without dead time");

  AST_DEAD_S4_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s4_o && !$past(s4_o) && $past(s3_o)) |-> ($past(dead_i) == '0)) // R9
    else $error("S4 on without dead time");
endmodule

// File: rtl/gate_pattern_gen.sv
module gate_pattern_gen #(
  parameter int unsigned STEP_CYC = 5,
  parameter int unsigned DUTY_W   = 8,
  parameter int unsigned DT_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              src_sel_i,
  input  logic [DUTY_W-1:0] duty_s1_i,
  input  logic [DUTY_W-1:0] duty_s2_i,
  input  logic [DUTY_W-1:0] duty_s3_i,
  input  logic [DT_W-1:0]   dead_i,
  output logic              s1_o,
  output logic              s2_o,
  output logic              s3_o,
  output logic              s4_o
);
  localparam int unsigned PERIOD = 4 * STEP_CYC;
  localparam int unsigned POS_W  = $clog2(PERIOD);

  logic [POS_W-1:0] pos;
  logic [1:0]       phase;
  logic             last;
  logic             load;
  logic             s3_req;

  assign load = last | ~en_i;

  gpg_timebase #(.STEP_CYC(STEP_CYC)) u_timebase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .pos_o   (pos),
    .phase_o (phase),
    .last_o  (last)
  );

  gpg_pattern #(.STEP_CYC(STEP_CYC), .DUTY_W(DUTY_W)) u_pattern (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .load_i    (load),
    .src_sel_i (src_sel_i),
    .duty_s1_i (duty_s1_i),
    .duty_s2_i (duty_s2_i),
    .duty_s3_i (duty_s3_i),
    .pos_i     (pos),
    .phase_i   (phase),
    .s1_o      (s1_o),
    .s2_o      (s2_o),
    .s3_req_o  (s3_req)
  );

  gpg_interlock #(.DT_W(DT_W)) u_interlock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .req_i  (s3_req),
    .dead_i (dead_i),
    .s3_o   (s3_o),
    .s4_o   (s4_o)
  );

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(s1_o || s2_o || s3_o || s4_o)) // R1
    else $error("gate active while disabled");
endmodule

// File: tb/gate_pattern_gen_tb_top.sv
module gate_pattern_gen_tb_top;
  localparam int STEP   = 5;
  localparam int PER    = 4 * STEP;
  localparam int CAP12  = PER / 5;
  localparam int CAP3   = (4 * PER) / 5;
  localparam int DUTY_W = 8;
  localparam int DT_W   = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic src_sel_i = 1'b0;
  logic [DUTY_W-1:0] duty_s1_i = '0;
  logic [DUTY_W-1:0] duty_s2_i = '0;
  logic [DUTY_W-1:0] duty_s3_i = '0;
  logic [DT_W-1:0]   dead_i = '0;
  logic s1_o, s2_o, s3_o, s4_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string tag = "R1";
  logic [3:0] exp_q[$];

  always #4 clk_i = ~clk_i;  // 125 MHz

  gate_pattern_gen #(.STEP_CYC(STEP), .DUTY_W(DUTY_W), .DT_W(DT_W)) dut_i (
    .clk_i, .rst_ni, .en_i, .src_sel_i, .duty_s1_i, .duty_s2_i, .duty_s3_i,
    .dead_i, .s1_o, .s2_o, .s3_o, .s4_o
  );

  // reference model built from the requirements
  int m_pos = 0, m_gap = 0;
  int m_d1 = 0, m_d2 = 0, m_d3 = 0;
  bit m_src = 0, m_side = 0, m_on = 0, m_s1 = 0, m_s2 = 0;

  function automatic int clampv(int v, int lim);
    return (v > lim) ? lim : v;
  endfunction

  task automatic load_model();
    m_d1 = clampv(int'(duty_s1_i), CAP12);
    m_d2 = clampv(int'(duty_s2_i), CAP12);
    m_d3 = clampv(int'(duty_s3_i), CAP3);
    m_src = src_sel_i;
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_pos = 0; m_gap = 0; m_side = 0; m_on = 0; m_s1 = 0; m_s2 = 0;
      m_d1 = 0; m_d2 = 0; m_d3 = 0; m_src = 0;
    end else begin
      if (!en_i) begin
        m_pos = 0; m_gap = 0; m_side = 0; m_on = 0; m_s1 = 0; m_s2 = 0;
        load_model();
      end else begin
        int ph;
        bit req;
        ph = m_pos / STEP;
        if (m_src) begin
          m_s1 = (ph < 2);
          m_s2 = (ph < 2);
          req  = (ph == 0) || (ph == 2);
        end else begin
          m_s1 = (m_pos < m_d1);
          m_s2 = (m_pos < m_d2);
          req  = (m_pos < m_d3);
        end
        if (req != m_side) begin
          m_side = req; m_gap = int'(dead_i); m_on = (dead_i == 0);
        end else if (m_gap != 0) begin
          m_on = (m_gap == 1); m_gap = m_gap - 1;
        end else begin
          m_on = 1;
        end
        if (m_pos == PER - 1) begin
          load_model();
          m_pos = 0;
        end else begin
          m_pos = m_pos + 1;
        end
      end
      exp_q.push_back({m_s1, m_s2, m_on & m_side, m_on & ~m_side});
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    cycles++;
    chk("R8", "s3&s4", int'(s3_o & s4_o), 0);
    if (exp_q.size() != 0) begin
      logic [3:0] e;
      e = exp_q.pop_front();
      chk(tag, "s1", int'(s1_o), int'(e[3]));
      chk(tag, "s2", int'(s2_o), int'(e[2]));
      chk(tag, "s3", int'(s3_o), int'(e[1]));
      chk(tag, "s4", int'(s4_o), int'(e[0]));
    end else begin
      chk("R1", "gates in reset", int'({s1_o, s2_o, s3_o, s4_o}), 0);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic set_duty(int a, int b, int c, int d);
    duty_s1_i = DUTY_W'(a);
    duty_s2_i = DUTY_W'(b);
    duty_s3_i = DUTY_W'(c);
    dead_i    = DT_W'(d);
  endtask

  int hi_cnt;

  initial begin
    step(3);
    tag = "R1";
    chk("R1", "reset gates", int'({s1_o, s2_o, s3_o, s4_o}), 0);
    rst_ni = 1'b1;
    step(3);

    // duty source, nominal words
    tag = "R2 R3 R4 R9";
    set_duty(2, 3, 10, 2);
    en_i = 1'b1;
    step(3 * PER);

    // clamping of oversized words; count S1 high cycles over one period
    tag = "R3 R4";
    set_duty(200, 5, 255, 1);
    step(2 * PER);
    hi_cnt = 0;
    for (int i = 0; i < PER; i++) begin
      hi_cnt += int'(s1_o);
      step(1);
    end
    chk("R3", "S1 clamped high count", hi_cnt, CAP12);

    // all-zero duty: S4 only
    tag = "R3 R4 R9";
    set_duty(0, 0, 0, 3);
    step(2 * PER + 3);

    // mid-period rewrites take effect at the wrap only
    tag = "R5";
    set_duty(4, 1, 12, 1);
    step(7);
    set_duty(1, 4, 3, 1);
    src_sel_i = 1'b1;
    step(5);
    set_duty(3, 2, 15, 1);
    src_sel_i = 1'b0;
    step(2 * PER);

    // counter source, direct swap
    tag = "R2 R5 R6 R7";
    set_duty(0, 0, 0, 0);
    src_sel_i = 1'b1;
    step(4 * PER);

    // counter source with dead time
    tag = "R7 R8 R9";
    dead_i = DT_W'(2);
    step(3 * PER);

    // enable drop in mid-period, restart with counter source at phase 0
    tag = "R1 R6";
    step(6);
    en_i = 1'b0;
    step(5);
    en_i = 1'b1;
    dead_i = DT_W'(0);
    step(2 * PER);

    // dead time longer than the S3 window
    tag = "R9";
    src_sel_i = 1'b0;
    set_duty(2, 2, 6, 15);
    step(4 * PER);

    // asynchronous reset in mid-run
    tag = "R1";
    step(3);
    rst_ni = 1'b0;
    #1;
    chk("R1", "async reset gates", int'({s1_o, s2_o, s3_o, s4_o}), 0);
    step(2);
    rst_ni = 1'b1;
    tag = "R1 R3 R4";
    step(2 * PER);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule